// File: doc/BRIEF.md
# Register Integration Table

This block sits beside the rename stage of an out-of-order core that also runs speculative helper threads. Each helper instruction, after it has been renamed into its own freshly allocated destination physical register, deposits a record in the table. The record holds the instruction's PC, the physical register tags of its two sources and its output physical register. A branch record also holds the outcome that the helper computed.

When the main thread renames an instruction, it presents the PC and its current source mappings. A hit means the helper already produced exactly this result from exactly these inputs. Rename then points the destination at the stored output register instead of allocating a new one. No register value is read or written. The entry is consumed by the hit, so an output register is never handed out twice. An integrated branch whose stored outcome disagrees with the front end's prediction raises a redirect straight away.

Entries are placed by the low PC bits into one of `SETS` sets of `WAYS` ways. A full set evicts its least recently inserted entry. Any displaced entry has its output physical register reported on the free port, so the register returns to the free list.

Top module: `reg_integ_table`

## Requirements
- R1: After reset the table is empty: no lookup hits, `free_valid` is 0 and `ins_ready` is 1 while no lookup is offered.
- R2: A lookup hits only when an entry has the same full PC and the same two source tags. `lk_hit` and the entry's output register on `lk_preg` appear on the cycle after the lookup.
- R3: A lookup that differs from every entry in the PC or in either source tag misses, and `lk_preg` is 0.
- R4: A hit removes its entry, so the same lookup repeated afterwards misses.
- R5: Dependent chains integrate step by step: an output register returned by one hit, used as a source tag of a later lookup, matches an entry inserted with that tag.
- R6: The set is PC bits [IDX_W-1:0], with IDX_W = log2(SETS). Inserts into one set never evict entries of another set.
- R7: An insert into a full set evicts the least recently inserted entry of that set. On the cycle after the insert, `free_valid` is 1 and `free_preg` is that entry's output register. An insert into a set with a free way reports nothing.
- R8: An insert whose PC and source tags equal an existing entry replaces it and frees the old output register on the next cycle. A later lookup returns the new register.
- R9: While a lookup is offered to the same set as an insert, `ins_ready` is 0 in that cycle and the insert is not written. The sender must present it again, and the lookup proceeds normally.
- R10: On a hit of a branch entry whose stored outcome differs from `lk_pred_taken`, `redirect` is 1 on the hit cycle and `redirect_taken` carries the stored outcome. With a matching prediction, with a non-branch entry or on a miss, `redirect` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Helper instruction insert request |
| ins_pc | input | PC_W | PC of the helper instruction |
| ins_src0 | input | PREG_W | First source physical tag |
| ins_src1 | input | PREG_W | Second source physical tag |
| ins_dst | input | PREG_W | Output physical register allocated by the helper |
| ins_is_br | input | 1 | Instruction is a conditional branch |
| ins_taken | input | 1 | Branch outcome computed by the helper |
| ins_ready | output | 1 | Insert accepted this cycle; 0 means retry |
| lk_valid | input | 1 | Main-thread rename lookup |
| lk_pc | input | PC_W | PC being renamed |
| lk_src0 | input | PREG_W | Current mapping of the first source |
| lk_src1 | input | PREG_W | Current mapping of the second source |
| lk_pred_taken | input | 1 | Front-end prediction for a branch |
| lk_hit | output | 1 | Previous cycle's lookup integrated |
| lk_preg | output | PREG_W | Output register to map the destination to (0 on miss) |
| redirect | output | 1 | Integrated branch was mispredicted |
| redirect_taken | output | 1 | Correct direction for the redirect |
| free_valid | output | 1 | An entry was displaced by the previous cycle's insert |
| free_preg | output | PREG_W | Physical register to return to the free list |

## Verification
`ins_ready` is combinational, so the bench checks it 1 ns after driving each stimulus, in the same cycle. Lookup results, redirects and free reports come from registers: each is due exactly one clock after its stimulus. Every step therefore drives inputs on a falling edge and compares all registered outputs on the next falling edge. The comparison is against a behavioural model of per-set insertion-ordered lists, which the model updates when the stimulus is applied. An insert becomes visible to a lookup one cycle after it is accepted, and the sequences are ordered to respect that.

// File: rtl/reg_integ_table.sv
module reg_integ_table #(
  parameter int PC_W   = 16,
  parameter int PREG_W = 6,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic [PREG_W-1:0] ins_src0,
  input  logic [PREG_W-1:0] ins_src1,
  input  logic [PREG_W-1:0] ins_dst,
  input  logic              ins_is_br,
  input  logic              ins_taken,
  output logic              ins_ready,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [PREG_W-1:0] lk_src0,
  input  logic [PREG_W-1:0] lk_src1,
  input  logic              lk_pred_taken,
  output logic              lk_hit,
  output logic [PREG_W-1:0] lk_preg,
  output logic              redirect,
  output logic              redirect_taken,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - IDX_W;

  logic [WAYS-1:0]   vld   [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [PREG_W-1:0] s0_q  [SETS][WAYS];
  logic [PREG_W-1:0] s1_q  [SETS][WAYS];
  logic [PREG_W-1:0] dst_q [SETS][WAYS];
  logic              br_q  [SETS][WAYS];
  logic              tk_q  [SETS][WAYS];
  logic [WAY_W-1:0]  age_q [SETS][WAYS];

  wire [IDX_W-1:0] li = lk_pc[IDX_W-1:0];
  wire [IDX_W-1:0] ii = ins_pc[IDX_W-1:0];
  wire [TAG_W-1:0] lt = lk_pc[PC_W-1:IDX_W];
  wire [TAG_W-1:0] it = ins_pc[PC_W-1:IDX_W];

  assign ins_ready = !(lk_valid && (li == ii));
  wire do_ins = ins_valid && ins_ready;

  logic             lmatch;
  logic [WAY_W-1:0] lway;
  always_comb begin
    lmatch = 1'b0;
    lway   = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld[li][w] && tag_q[li][w] == lt && s0_q[li][w] == lk_src0 && s1_q[li][w] == lk_src1) begin
        lmatch = 1'b1;
        lway   = WAY_W'(w);
      end
  end
  wire hit_go = lk_valid && lmatch;

  logic [WAY_W-1:0] vict;
  always_comb begin
    vict = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[ii][w] == WAY_W'(WAYS-1)) vict = WAY_W'(w);
    for (int w = WAYS-1; w >= 0; w--)
      if (!vld[ii][w]) vict = WAY_W'(w);
    for (int w = 0; w < WAYS; w++)
      if (vld[ii][w] && tag_q[ii][w] == it && s0_q[ii][w] == ins_src0 && s1_q[ii][w] == ins_src1)
        vict = WAY_W'(w);
  end
  wire evict = do_ins && vld[ii][vict];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
      lk_hit         <= 1'b0;
      lk_preg        <= '0;
      redirect       <= 1'b0;
      redirect_taken <= 1'b0;
      free_valid     <= 1'b0;
      free_preg      <= '0;
    end else begin
      lk_hit         <= hit_go;
      lk_preg        <= hit_go ? dst_q[li][lway] : '0;
      redirect       <= hit_go && br_q[li][lway] && (tk_q[li][lway] != lk_pred_taken);
      redirect_taken <= hit_go && tk_q[li][lway];
      free_valid     <= evict;
      free_preg      <= evict ? dst_q[ii][vict] : '0;
      if (hit_go) vld[li][lway] <= 1'b0;
      if (do_ins) begin
        vld[ii][vict] <= 1'b1;
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == vict) age_q[ii][w] <= '0;
          else if (age_q[ii][w] < age_q[ii][vict]) age_q[ii][w] <= age_q[ii][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_ins) begin
      tag_q[ii][vict] <= it;
      s0_q[ii][vict]  <= ins_src0;
      s1_q[ii][vict]  <= ins_src1;
      dst_q[ii][vict] <= ins_dst;
      br_q[ii][vict]  <= ins_is_br;
      tk_q[ii][vict]  <= ins_taken;
    end
  end
endmodule

module reg_integ_table_chk (
  input logic clk,
  input logic rst_n,
  input logic ins_valid,
  input logic ins_ready,
  input logic lk_valid,
  input logic lk_pred_taken,
  input logic lk_hit,
  input logic redirect,
  input logic redirect_taken,
  input logic free_valid
);
  p_hit_after_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid));
  p_free_after_insert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> $past(ins_valid));
  p_stall_needs_lookup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_ready |-> lk_valid);
  p_redirect_on_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> lk_hit);
  p_redirect_flips_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (redirect_taken != $past(lk_pred_taken)));
endmodule

bind reg_integ_table reg_integ_table_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .lk_valid(lk_valid), .lk_pred_taken(lk_pred_taken), .lk_hit(lk_hit),
  .redirect(redirect), .redirect_taken(redirect_taken), .free_valid(free_valid)
);

// File: tb/test_reg_integ_table.sv
module test_reg_integ_table;
  localparam int PC_W = 16, PREG_W = 6, SETS = 16, WAYS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_is_br = 0, ins_taken = 0, lk_valid = 0, lk_pred_taken = 0;
  logic [PC_W-1:0] ins_pc = '0, lk_pc = '0;
  logic [PREG_W-1:0] ins_src0 = '0, ins_src1 = '0, ins_dst = '0, lk_src0 = '0, lk_src1 = '0;
  logic ins_ready, lk_hit, redirect, redirect_taken, free_valid;
  logic [PREG_W-1:0] lk_preg, free_preg;

  always #10 clk = ~clk;

  reg_integ_table #(.PC_W(PC_W), .PREG_W(PREG_W), .SETS(SETS), .WAYS(WAYS)) i_reg_integ_table (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_src0(ins_src0),
    .ins_src1(ins_src1), .ins_dst(ins_dst), .ins_is_br(ins_is_br), .ins_taken(ins_taken),
    .ins_ready(ins_ready), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_src0(lk_src0),
    .lk_src1(lk_src1), .lk_pred_taken(lk_pred_taken), .lk_hit(lk_hit), .lk_preg(lk_preg),
    .redirect(redirect), .redirect_taken(redirect_taken), .free_valid(free_valid),
    .free_preg(free_preg));

  int m_pc [SETS][WAYS];
  int m_s0 [SETS][WAYS];
  int m_s1 [SETS][WAYS];
  int m_d  [SETS][WAYS];
  int m_br [SETS][WAYS];
  int m_tk [SETS][WAYS];
  int m_n  [SETS];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int find(int s, int pc, int a, int b);
    for (int k = 0; k < m_n[s]; k++)
      if (m_pc[s][k] == pc && m_s0[s][k] == a && m_s1[s][k] == b) return k;
    return -1;
  endfunction

  task automatic drop(int s, int k);
    for (int j = k; j < m_n[s] - 1; j++) begin
      m_pc[s][j] = m_pc[s][j+1]; m_s0[s][j] = m_s0[s][j+1]; m_s1[s][j] = m_s1[s][j+1];
      m_d[s][j] = m_d[s][j+1]; m_br[s][j] = m_br[s][j+1]; m_tk[s][j] = m_tk[s][j+1];
    end
    m_n[s]--;
  endtask

  task automatic ins(int pc, int a, int b, int d, bit br = 0, bit tk = 0);
    ins_valid = 1; ins_pc = PC_W'(pc); ins_src0 = PREG_W'(a); ins_src1 = PREG_W'(b);
    ins_dst = PREG_W'(d); ins_is_br = br; ins_taken = tk;
  endtask

  task automatic lk(int pc, int a, int b, bit pt = 0);
    lk_valid = 1; lk_pc = PC_W'(pc); lk_src0 = PREG_W'(a); lk_src1 = PREG_W'(b); lk_pred_taken = pt;
  endtask

  task automatic step(string tag);
    int s, k, e_preg, e_fp;
    bit rdy, e_hit, e_red, e_rtk, e_free;
    e_hit = 0; e_red = 0; e_rtk = 0; e_free = 0; e_preg = 0; e_fp = 0;
    #1;
    rdy = !(lk_valid && (int'(lk_pc) % SETS) == (int'(ins_pc) % SETS));
    chk(tag, "ins_ready", int'(ins_ready), int'(rdy));
    if (lk_valid) begin
      s = int'(lk_pc) % SETS;
      k = find(s, int'(lk_pc), int'(lk_src0), int'(lk_src1));
      if (k >= 0) begin
        e_hit = 1; e_preg = m_d[s][k]; e_rtk = m_tk[s][k] != 0;
        e_red = m_br[s][k] != 0 && (m_tk[s][k] != int'(lk_pred_taken));
        drop(s, k);
      end
    end
    if (ins_valid && rdy) begin
      s = int'(ins_pc) % SETS;
      k = find(s, int'(ins_pc), int'(ins_src0), int'(ins_src1));
      if (k >= 0) begin e_free = 1; e_fp = m_d[s][k]; drop(s, k); end
      else if (m_n[s] == WAYS) begin e_free = 1; e_fp = m_d[s][0]; drop(s, 0); end
      k = m_n[s];
      m_pc[s][k] = int'(ins_pc); m_s0[s][k] = int'(ins_src0); m_s1[s][k] = int'(ins_src1);
      m_d[s][k] = int'(ins_dst); m_br[s][k] = int'(ins_is_br); m_tk[s][k] = int'(ins_taken);
      m_n[s]++;
    end
    @(negedge clk);
    chk(tag, "lk_hit", int'(lk_hit), int'(e_hit));
    chk(tag, "lk_preg", int'(lk_preg), e_preg);
    chk(tag, "redirect", int'(redirect), int'(e_red));
    chk(tag, "redirect_taken", int'(redirect_taken), int'(e_rtk));
    chk(tag, "free_valid", int'(free_valid), int'(e_free));
    chk(tag, "free_preg", int'(free_preg), e_fp);
    ins_valid = 0; lk_valid = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) m_n[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    chk("R1", "free_valid", int'(free_valid), 0);
    chk("R1", "lk_hit", int'(lk_hit), 0);
    step("R1");
    lk(16'h0010, 3, 4); step("R1");
    // R2: exact match hits
    ins(16'h0010, 3, 4, 20); step("R2");
    lk(16'h0010, 3, 4); step("R2");
    // R4: consumed entry misses
    lk(16'h0010, 3, 4); step("R4");
    // R3: any field differing misses
    ins(16'h0020, 5, 6, 21); step("R3");
    lk(16'h0020, 9, 6); step("R3");
    lk(16'h0020, 5, 7); step("R3");
    lk(16'h0120, 5, 6); step("R3");
    lk(16'h0020, 5, 6); step("R2");
    // R5: chain through integrated register
    ins(16'h0031, 7, 7, 22); step("R5");
    ins(16'h0035, 22, 8, 23); step("R5");
    lk(16'h0031, 7, 7); step("R5");
    lk(16'h0035, 22, 8); step("R5");
    // R6 / R7: set fill, oldest eviction, other set untouched
    ins(16'h0002, 1, 1, 30); step("R7");
    ins(16'h0012, 1, 1, 31); step("R7");
    ins(16'h0022, 1, 1, 32); step("R7");
    ins(16'h0032, 1, 1, 33); step("R7");
    ins(16'h0003, 1, 1, 35); step("R6");
    ins(16'h0042, 1, 1, 34); step("R7");
    lk(16'h0003, 1, 1); step("R6");
    lk(16'h0002, 1, 1); step("R7");
    lk(16'h0012, 1, 1); step("R7");
    ins(16'h0052, 1, 1, 36); step("R7");
    ins(16'h0062, 1, 1, 37); step("R7");
    lk(16'h0042, 1, 1); step("R7");
    // R8: identical key replaces and frees
    ins(16'h0007, 1, 2, 40); step("R8");
    ins(16'h0007, 1, 2, 41); step("R8");
    lk(16'h0007, 1, 2); step("R8");
    // R9: same-set conflict stalls insert
    ins(16'h0008, 2, 2, 42); lk(16'h0018, 2, 2); step("R9");
    lk(16'h0008, 2, 2); step("R9");
    ins(16'h0008, 2, 2, 42); step("R9");
    ins(16'h0009, 2, 2, 43); lk(16'h0008, 2, 2); step("R9");
    lk(16'h0009, 2, 2); step("R9");
    // R10: branch redirects
    ins(16'h000B, 4, 4, 44, 1, 1); step("R10");
    lk(16'h000B, 4, 4, 0); step("R10");
    ins(16'h000C, 4, 4, 45, 1, 0); step("R10");
    lk(16'h000C, 4, 4, 0); step("R10");
    ins(16'h000D, 4, 4, 46, 0, 1); step("R10");
    lk(16'h000D, 4, 4, 0); step("R10");
    lk(16'h000E, 4, 4, 1); step("R10");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule